// File: doc/BRIEF.md
# Horizontal Clamp and Blank Pulse Sequencer

This block produces the four per-line horizontal control pulses used when reading out an image sensor: a horizontal blanking pulse, an optical-black clamp pulse, a dummy-pixel clamp pulse and a pre-blanking pulse. A 12-bit position counter restarts a fixed number of clock edges after each falling edge of the line sync input `hd_i`. From that point it counts one step per clock until it reaches the programmed line length.

The line is split into up to four regions by three programmable boundary positions. Each region has a pointer per output that picks one of four stored sequences for that output. A sequence holds two toggle positions and a start level. When the line restarts, each output is loaded with the start level of the sequence picked for region 0. After that, the output inverts whenever the counter takes one of the toggle positions of the sequence picked for the region being entered. All storage is written through a simple single-cycle write port.

Top module: `hline_pulse_seq`

## Requirements
- R1: After reset all four pulse outputs are 0 and `region_o` is 0. Storage resets to line length 4095, every boundary 4095, every pointer 0, and every sequence with both toggle positions 0 and start level 0, so a line run on defaults keeps all outputs at 0.
- R2: The edge on which `hd_i` is first sampled low after being high is edge 1. On edge 6 the position counter becomes 0 and each output takes its start value. Nothing changes earlier.
- R3: On the restart edge, each output is set to the start level of the sequence that its region-0 pointer selects. A start level written during a line has no effect until the next restart.
- R4: Each later edge advances the counter by one. An output inverts on the edge at which the counter takes the value of one of its selected toggle positions. Between such edges it holds.
- R5: The counter stops at the line length L (write address 0x00). Only positions below L are live, so a toggle position at or above L never fires.
- R6: `region_o` steps from r to r+1 on the edge at which the counter takes boundary r+1. Boundary k (k = 1..3) is written at address k. The index never passes 3 and returns to 0 on restart.
- R7: Pointer word for region r is written at address 0x04+r. Bits [1:0] select the blank sequence, [3:2] the optical-black clamp sequence, [5:4] the dummy clamp sequence and [7:6] the pre-blank sequence. Toggle comparison uses the sequences of the region being entered on that edge.
- R8: Sequence fields are written at 0x40 | sig<<4 | seq<<2 | fld. The signal codes are blank 0, optical-black clamp 1, dummy clamp 2 and pre-blank 3. Field 0 is the first toggle position, field 1 the second, and field 2 is the start level in data bit 0.
- R9: Two equal toggle positions cancel each other. A toggle position of 0 applies on the restart edge and inverts the start level.
- R10: Writes to any address outside the map, including field 3 and addresses 0x08-0x3F and 0x80-0xFF, change nothing.
- R11: Only a falling edge of `hd_i` restarts the line. Holding it low or raising it leaves the counter running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Line sync; falling edge starts a line |
| cfg_we_i | input | 1 | Write strobe |
| cfg_addr_i | input | 8 | Write address |
| cfg_wdata_i | input | 12 | Write data |
| blank_o | output | 1 | Horizontal blanking pulse |
| ob_clamp_o | output | 1 | Optical-black clamp pulse |
| dummy_clamp_o | output | 1 | Dummy-pixel clamp pulse |
| preblank_o | output | 1 | Pre-blanking pulse |
| region_o | output | 2 | Current line region index |

## Verification
The hardest case is the edge on which a region boundary and a toggle position coincide. On that edge the output must follow the sequence of the region being entered, not the one being left. The counter itself cannot be seen at the ports, so the stimulus derives every position from a fixed count of clock edges after a controlled falling edge of `hd_i`. The stimulus places a toggle of a sequence used only in region 2 exactly on the boundary of region 2. The sample taken one position earlier must show the output unchanged.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int CNT_W      = 12;
  localparam int DATA_W     = 12;
  localparam int ADDR_W     = 8;
  localparam int NUM_SIG    = 4;
  localparam int NUM_SEQ    = 4;
  localparam int NUM_REGION = 4;
  localparam int SEQ_W      = $clog2(NUM_SEQ);
  localparam int REG_W      = $clog2(NUM_REGION);

  localparam logic [ADDR_W-1:0] ADDR_LEN      = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_PTR_BASE = 8'h04;
  localparam logic [1:0]        SEQ_AREA      = 2'b01;

  typedef enum logic [1:0] {
    FLD_TA  = 2'd0,
    FLD_TB  = 2'd1,
    FLD_POL = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;

  typedef struct packed {
    logic [CNT_W-1:0] t_a;
    logic [CNT_W-1:0] t_b;
    logic             pol;
  } seq_t;
endpackage

// File: rtl/hcs_cfg_regs.sv
module hcs_cfg_regs
  import hcs_pkg::*;
(
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        we_i,
  input  logic [ADDR_W-1:0]                           addr_i,
  input  logic [DATA_W-1:0]                           wdata_i,
  output logic [CNT_W-1:0]                            line_len_o,
  output logic [NUM_REGION-1:0][CNT_W-1:0]            bnd_o,
  output logic [NUM_REGION-1:0][NUM_SIG-1:0][SEQ_W-1:0] ptr_o,
  output logic [NUM_SIG-1:0]                          seq_we_o,
  output logic [SEQ_W-1:0]                            seq_idx_o,
  output fld_e                                        seq_fld_o
);
  localparam int PTR_BITS = NUM_SIG * SEQ_W;

  logic is_seq;
  assign is_seq    = (addr_i[7:6] == SEQ_AREA) && (addr_i[1:0] != FLD_NONE);
  assign seq_idx_o = addr_i[3:2];
  assign seq_fld_o = fld_e'(addr_i[1:0]);

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_seq_we
    assign seq_we_o[s] = we_i && is_seq && (addr_i[5:4] == 2'(s));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          line_len_o <= '1;
    else if (we_i && addr_i == ADDR_LEN)  line_len_o <= wdata_i[CNT_W-1:0];
  end

  assign bnd_o[0] = '0;
  for (genvar r = 1; r < NUM_REGION; r++) begin : g_bnd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              bnd_o[r] <= '1;
      else if (we_i && addr_i == ADDR_W'(r))    bnd_o[r] <= wdata_i[CNT_W-1:0];
    end
  end

  for (genvar r = 0; r < NUM_REGION; r++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ptr_o[r] <= '0;
      else if (we_i && addr_i == ADDR_PTR_BASE + ADDR_W'(r))
        ptr_o[r] <= wdata_i[PTR_BITS-1:0];
    end
  end
endmodule

// File: rtl/hcs_line_timer.sv
module hcs_line_timer
  import hcs_pkg::*;
#(
  parameter int SYNC_EDGES = 6   // must be >= 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             hd_i,
  input  logic [CNT_W-1:0]                 line_len_i,
  input  logic [NUM_REGION-1:0][CNT_W-1:0] bnd_i,
  output logic                             sync_o,
  output logic                             live_o,
  output logic [CNT_W-1:0]                 pos_nxt_o,
  output logic [REG_W-1:0]                 region_nxt_o,
  output logic [REG_W-1:0]                 region_o
);
  localparam int PIPE_W = SYNC_EDGES - 1;
  localparam logic [REG_W-1:0] LAST_REG = REG_W'(NUM_REGION - 1);

  logic              hd_q;
  logic [PIPE_W-1:0] pipe_q;
  logic [CNT_W-1:0]  cnt_q, cnt_inc;
  logic [REG_W-1:0]  region_q, region_up;
  logic              fall, running, adv;

  assign fall      = hd_q & ~hd_i;
  assign sync_o    = pipe_q[PIPE_W-1];
  assign running   = cnt_q < line_len_i;
  assign cnt_inc   = cnt_q + CNT_W'(1);
  assign region_up = region_q + REG_W'(1);

  assign pos_nxt_o = sync_o ? '0 : (running ? cnt_inc : cnt_q);
  assign live_o    = sync_o ? (line_len_i != '0) : (running && (cnt_inc < line_len_i));
  assign adv       = !sync_o && running && (region_q != LAST_REG) && (cnt_inc == bnd_i[region_up]);
  assign region_nxt_o = sync_o ? '0 : (adv ? region_up : region_q);
  assign region_o     = region_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_q     <= 1'b1;
      pipe_q   <= '0;
      cnt_q    <= '1;
      region_q <= '0;
    end else begin
      hd_q     <= hd_i;
      pipe_q   <= {pipe_q[PIPE_W-2:0], fall};
      cnt_q    <= pos_nxt_o;
      region_q <= region_nxt_o;
    end
  end

  p_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> (cnt_q == '0 && region_q == '0));

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_o && running) |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));

  p_cnt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_o && !running) |=> $stable(cnt_q));

  p_region_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_q != $past(region_q)) |->
      (region_q == REG_W'($past(region_q) + 1) || region_q == '0));
endmodule

// File: rtl/hcs_pulse_chan.sv
module hcs_pulse_chan
  import hcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seq_we_i,
  input  logic [SEQ_W-1:0]  seq_idx_i,
  input  fld_e              seq_fld_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEQ_W-1:0]  sel_i,
  input  logic              sync_i,
  input  logic              live_i,
  input  logic [CNT_W-1:0]  pos_i,
  output logic              pulse_o
);
  seq_t seq_q [NUM_SEQ];
  seq_t cur;
  logic hit;

  assign cur = seq_q[sel_i];
  // equal positions cancel
  assign hit = live_i && ((pos_i == cur.t_a) ^ (pos_i == cur.t_b));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SEQ; i++) seq_q[i] <= '0;
    end else if (seq_we_i) begin
      case (seq_fld_i)
        FLD_TA:  seq_q[seq_idx_i].t_a <= wdata_i[CNT_W-1:0];
        FLD_TB:  seq_q[seq_idx_i].t_b <= wdata_i[CNT_W-1:0];
        FLD_POL: seq_q[seq_idx_i].pol <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pulse_o <= 1'b0;
    else if (sync_i) pulse_o <= cur.pol ^ hit;
    else if (hit)    pulse_o <= ~pulse_o;
  end

  p_dead_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !live_i) |=> $stable(pulse_o));

  p_no_pos_no_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && pos_i != cur.t_a && pos_i != cur.t_b) |=> $stable(pulse_o));
endmodule

// File: rtl/hline_pulse_seq.sv
module hline_pulse_seq
  import hcs_pkg::*;
#(
  parameter int SYNC_EDGES = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hd_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              blank_o,
  output logic              ob_clamp_o,
  output logic              dummy_clamp_o,
  output logic              preblank_o,
  output logic [REG_W-1:0]  region_o
);
  logic [CNT_W-1:0]                             line_len;
  logic [NUM_REGION-1:0][CNT_W-1:0]             bnd;
  logic [NUM_REGION-1:0][NUM_SIG-1:0][SEQ_W-1:0] ptr;
  logic [NUM_SIG-1:0]                           seq_we;
  logic [SEQ_W-1:0]                             seq_idx;
  fld_e                                         seq_fld;
  logic                                         sync, live;
  logic [CNT_W-1:0]                             pos_nxt;
  logic [REG_W-1:0]                             region_nxt;
  logic [NUM_SIG-1:0]                           pulse;

  hcs_cfg_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .line_len_o (line_len),
    .bnd_o      (bnd),
    .ptr_o      (ptr),
    .seq_we_o   (seq_we),
    .seq_idx_o  (seq_idx),
    .seq_fld_o  (seq_fld)
  );

  hcs_line_timer #(.SYNC_EDGES(SYNC_EDGES)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hd_i         (hd_i),
    .line_len_i   (line_len),
    .bnd_i        (bnd),
    .sync_o       (sync),
    .live_o       (live),
    .pos_nxt_o    (pos_nxt),
    .region_nxt_o (region_nxt),
    .region_o     (region_o)
  );

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_chan
    hcs_pulse_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .seq_we_i  (seq_we[s]),
      .seq_idx_i (seq_idx),
      .seq_fld_i (seq_fld),
      .wdata_i   (cfg_wdata_i),
      .sel_i     (ptr[region_nxt][s]),  // region being entered
      .sync_i    (sync),
      .live_i    (live),
      .pos_i     (pos_nxt),
      .pulse_o   (pulse[s])
    );
  end

  assign blank_o       = pulse[0];
  assign ob_clamp_o    = pulse[1];
  assign dummy_clamp_o = pulse[2];
  assign preblank_o    = pulse[3];

  p_region_zero_after_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync |=> (region_o == '0));
endmodule

// File: tb/hline_pulse_seq_tb.sv
module hline_pulse_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hd_i = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [11:0] cfg_wdata_i = '0;
  logic        blank_o, ob_clamp_o, dummy_clamp_o, preblank_o;
  logic [1:0]  region_o;

  int n_run = 0, n_fail = 0, pos = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  hline_pulse_seq u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at pos %0d: got %0d expected %0d", req, pos, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  function automatic logic [7:0] sa(input int sig, input int seq, input int fld);
    return 8'h40 | 8'(sig << 4) | 8'(seq << 2) | 8'(fld);
  endfunction

  task automatic start_line();
    @(negedge clk_i); hd_i = 1'b1;
    @(negedge clk_i); hd_i = 1'b0;
    repeat (6) @(posedge clk_i);
    @(negedge clk_i);
    pos = 0;
  endtask

  task automatic go(input int p);
    repeat (p - pos) @(negedge clk_i);
    pos = p;
  endtask

  task automatic t_reset();
    chk("R1 blank", blank_o, 0); chk("R1 obclamp", ob_clamp_o, 0);
    chk("R1 dclamp", dummy_clamp_o, 0); chk("R1 preblank", preblank_o, 0);
    chk("R1 region", region_o, 0);
    start_line(); go(100);
    chk("R1 defaults outputs", {blank_o, ob_clamp_o, dummy_clamp_o, preblank_o}, 0);
    chk("R1 defaults region", region_o, 0);
  endtask

  task automatic t_sync();
    wr(sa(0,0,2), 12'd1); wr(sa(0,0,0), 12'd4095); wr(sa(0,0,1), 12'd4095);
    chk("R3 start level waits for restart", blank_o, 0);
    @(negedge clk_i); hd_i = 1'b1;
    @(negedge clk_i); hd_i = 1'b0;
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    chk("R2 no change before edge 6", blank_o, 0);
    @(posedge clk_i); @(negedge clk_i);
    pos = 0;
    chk("R2 R3 start level on edge 6", blank_o, 1);
    chk("R3 obclamp start level 0", ob_clamp_o, 0);
  endtask

  task automatic t_toggle();
    wr(sa(1,0,0), 12'd10); wr(sa(1,0,1), 12'd20);
    start_line();
    go(9);  chk("R4 before first toggle", ob_clamp_o, 0);
    go(10); chk("R4 first toggle", ob_clamp_o, 1);
    go(19); chk("R4 hold", ob_clamp_o, 1);
    go(20); chk("R4 second toggle", ob_clamp_o, 0);
  endtask

  task automatic t_len();
    wr(8'h00, 12'd30);
    wr(sa(2,0,0), 12'd5); wr(sa(2,0,1), 12'd35);
    wr(sa(3,0,0), 12'd30); wr(sa(3,0,1), 12'd31);
    start_line();
    go(29);  chk("R5 toggle inside line", dummy_clamp_o, 1);
    go(100); chk("R5 toggle past length ignored", dummy_clamp_o, 1);
    chk("R5 toggle at length ignored", preblank_o, 0);
    wr(8'h00, 12'd4095);
  endtask

  task automatic t_regions();
    wr(8'h01, 12'd50); wr(8'h02, 12'd100); wr(8'h03, 12'd150);
    start_line();
    go(49);  chk("R6 region 0", region_o, 0);
    go(50);  chk("R6 region 1", region_o, 1);
    go(99);  chk("R6 region 1 hold", region_o, 1);
    go(100); chk("R6 region 2", region_o, 2);
    go(150); chk("R6 region 3", region_o, 3);
    go(300); chk("R6 stays at 3", region_o, 3);
    start_line();
    chk("R6 back to 0 on restart", region_o, 0);
  endtask

  task automatic t_pointers();
    wr(sa(0,1,0), 12'd60); wr(sa(0,1,1), 12'd70);
    wr(sa(3,2,0), 12'd100); wr(sa(3,2,1), 12'd4000);
    wr(8'h05, 12'h001); wr(8'h06, 12'h080);
    start_line();
    go(49);  chk("R7 region0 uses seq0", blank_o, 1);
    go(59);  chk("R7 region1 before toggle", blank_o, 1);
    go(60);  chk("R7 region1 seq1 toggle", blank_o, 0);
    go(70);  chk("R7 region1 seq1 second", blank_o, 1);
    go(99);  chk("R7 preblank before boundary", preblank_o, 0);
    go(100); chk("R7 toggle on boundary uses new region", preblank_o, 1);
  endtask

  task automatic t_cancel();
    wr(sa(2,3,0), 12'd40); wr(sa(2,3,1), 12'd40);
    wr(sa(1,3,0), 12'd0);  wr(sa(1,3,1), 12'd4000);
    wr(8'h04, 12'h03C);
    start_line();
    chk("R9 zero position inverts start", ob_clamp_o, 1);
    go(10); chk("R8 seq3 field map", ob_clamp_o, 1);
    go(41); chk("R9 equal positions cancel", dummy_clamp_o, 0);
  endtask

  task automatic t_unmapped();
    wr(8'hDC, 12'd7); wr(8'h5F, 12'd1); wr(8'h08, 12'hFFF); wr(8'h9C, 12'd3);
    start_line();
    chk("R10 field 3 ignored", ob_clamp_o, 1);
    go(10); chk("R10 high area ignored", ob_clamp_o, 1);
    go(41); chk("R10 dclamp intact", dummy_clamp_o, 0);
    go(50); chk("R10 boundary intact", region_o, 1);
  endtask

  task automatic t_level();
    start_line();
    go(160);
    hd_i = 1'b1;
    go(200); chk("R11 rising edge ignored", region_o, 3);
    go(300); chk("R11 line keeps running", preblank_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sync();
    t_toggle();
    t_len();
    t_regions();
    t_pointers();
    t_cancel();
    t_unmapped();
    t_level();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule